// File: doc/BRIEF.md
# Configuration Access Router

The router receives one configuration request at a time. Each request carries a bus number, the primary bus of that bus, a device, a function, a 12-bit register offset, an access size in bytes and, for writes, the data. The router screens the request, sends it to one of two targets, and returns a status code and, for reads, the data.

Requests whose bus equals the root bus number go to the local root-port register space. That space is 32 bits wide and is addressed by word. Every other request goes to an external window. The window takes a flat byte offset built from the request fields in the ECAM layout. Sub-word writes to the local space are done as a read followed by a merged write-back. This is because the local port has no byte enables. As a result, such writes rewrite the neighbouring bytes of the same word, including any write-one-to-clear bits in them.

Both targets use a request/acknowledge port. The request is held until the acknowledge arrives, and read data is valid in the cycle the acknowledge is high.

Top module: `cfg_router`

## Requirements
- R1: A request is rejected with status 1 (device not found) when its device is not 0 and either its bus or its primary bus equals `root_bus`. Neither target sees an access for it. This check takes priority over R4.
- R2: A request whose bus equals `root_bus` accesses only the local port. Any other accepted request accesses only the external port. The two ports are never requested in the same cycle.
- R3: The external byte offset is built as bus[7:0] in bits 27:20, device[4:0] in bits 19:15, function[2:0] in bits 14:12 and register[11:0] in bits 11:0. The size is passed through unchanged. Write data is right-justified and masked to the size.
- R4: The request returns status 2 (bad register number), with no target access, if its size is not 1, 2 or 4, or if its offset is not a multiple of its size.
- R5: A 1- or 2-byte local write first reads the word at `register[11:2]`. It then writes that word back with the byte lanes starting at bit (offset mod 4)×8 replaced by the new data. All other bytes keep their old values.
- R6: A 4-byte local write makes exactly one write access and no read access.
- R7: Read data is returned right-justified. Bytes above the access size are zero. For a local read, the data is taken from byte lane (offset mod 4).
- R8: `req_busy` rises in the cycle after a request is accepted and stays high until the response. `rsp_valid` is high for exactly one cycle. `req_valid` is ignored while busy.
- R9: A request that passes R1 and R4 completes with status 0.
- R10: After reset the router is idle. `req_busy`, `rsp_valid`, `loc_req` and `ext_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_bus | input | 8 | Root bus number |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_primary | input | 8 | Primary bus of the target bus |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_reg | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Right-justified write data |
| req_busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 device not found, 2 bad register |
| rsp_data | output | 32 | Right-justified read data |
| loc_req | output | 1 | Local space access request |
| loc_we | output | 1 | Local access is a write |
| loc_addr | output | 10 | Local word address |
| loc_wdata | output | 32 | Local write word |
| loc_rdata | input | 32 | Local read word |
| loc_ack | input | 1 | Local access done |
| ext_req | output | 1 | External window request |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | 28 | External byte offset |
| ext_size | output | 3 | External access size in bytes |
| ext_wdata | output | 32 | External write data, masked |
| ext_rdata | input | 32 | External read data, right-justified |
| ext_ack | input | 1 | External access done |

## Verification
The response to a request rejected under R1 or R4 appears in the cycle after the accepting edge. A request that reaches a target responds one cycle after that target's acknowledge. A narrow local write needs two acknowledges before it responds.

The bench models both targets with an acknowledge delayed by one register. It does not predict an exact response cycle. Instead, each task waits for `rsp_valid` at falling edges and samples status and data there, then checks the access counts gathered from the target ports.

The ignored-request case and the single-cycle strobe are checked by watching `rsp_valid` for several cycles after the response.

// File: rtl/cfg_router.sv
module cfg_router (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  root_bus,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_bus,
  input  logic [7:0]  req_primary,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_fn,
  input  logic [11:0] req_reg,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        req_busy,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic [31:0] rsp_data,
  output logic        loc_req,
  output logic        loc_we,
  output logic [9:0]  loc_addr,
  output logic [31:0] loc_wdata,
  input  logic [31:0] loc_rdata,
  input  logic        loc_ack,
  output logic        ext_req,
  output logic        ext_we,
  output logic [27:0] ext_addr,
  output logic [2:0]  ext_size,
  output logic [31:0] ext_wdata,
  input  logic [31:0] ext_rdata,
  input  logic        ext_ack
);
  typedef enum logic [2:0] {S_IDLE, S_LRD, S_LWR, S_EXT, S_RSP} state_t;

  state_t      state;
  logic        wr_q;
  logic [7:0]  bus_q;
  logic [4:0]  dev_q;
  logic [2:0]  fn_q;
  logic [11:0] reg_q;
  logic [2:0]  sz_q;
  logic [31:0] wd_q;
  logic [31:0] word_q;

  logic accept, not_found, bad_size, misaligned;
  logic [31:0] mask_q;
  logic [4:0]  shift_q;

  assign accept     = (state == S_IDLE) && req_valid;
  assign not_found  = (req_dev != 5'd0) && ((req_bus == root_bus) || (req_primary == root_bus));
  assign bad_size   = !((req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4));
  assign misaligned = ((req_size == 3'd2) && req_reg[0]) ||
                      ((req_size == 3'd4) && (req_reg[1:0] != 2'b00));

  assign mask_q  = (sz_q == 3'd1) ? 32'h0000_00FF :
                   (sz_q == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign shift_q = {reg_q[1:0], 3'b000};

  assign req_busy  = (state != S_IDLE);
  assign rsp_valid = (state == S_RSP);

  assign loc_req   = (state == S_LRD) || (state == S_LWR);
  assign loc_we    = (state == S_LWR);
  assign loc_addr  = reg_q[11:2];
  assign loc_wdata = word_q;

  assign ext_req   = (state == S_EXT);
  assign ext_we    = wr_q;
  assign ext_addr  = {bus_q, dev_q, fn_q, reg_q};
  assign ext_size  = sz_q;
  assign ext_wdata = wd_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wr_q       <= 1'b0;
      bus_q      <= '0;
      dev_q      <= '0;
      fn_q       <= '0;
      reg_q      <= '0;
      sz_q       <= '0;
      wd_q       <= '0;
      word_q     <= '0;
      rsp_status <= 2'd0;
      rsp_data   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          wr_q     <= req_write;
          bus_q    <= req_bus;
          dev_q    <= req_dev;
          fn_q     <= req_fn;
          reg_q    <= req_reg;
          sz_q     <= req_size;
          wd_q     <= req_wdata;
          word_q   <= req_wdata;
          rsp_data <= '0;
          if (not_found) begin
            rsp_status <= 2'd1;
            state      <= S_RSP;
          end else if (bad_size || misaligned) begin
            rsp_status <= 2'd2;
            state      <= S_RSP;
          end else begin
            rsp_status <= 2'd0;
            if (req_bus != root_bus)
              state <= S_EXT;
            else if (req_write && (req_size == 3'd4))
              state <= S_LWR;
            else
              state <= S_LRD;
          end
        end
        S_LRD: if (loc_ack) begin
          if (wr_q) begin
            word_q <= (loc_rdata & ~(mask_q << shift_q)) | ((wd_q & mask_q) << shift_q);
            state  <= S_LWR;
          end else begin
            rsp_data <= (loc_rdata >> shift_q) & mask_q;
            state    <= S_RSP;
          end
        end
        S_LWR: if (loc_ack) state <= S_RSP;
        S_EXT: if (ext_ack) begin
          if (!wr_q) rsp_data <= ext_rdata & mask_q;
          state <= S_RSP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module cfg_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  root_bus,
  input logic        req_valid,
  input logic        req_busy,
  input logic [7:0]  req_bus,
  input logic [7:0]  req_primary,
  input logic [4:0]  req_dev,
  input logic [11:0] req_reg,
  input logic [2:0]  req_size,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [31:0] rsp_data,
  input logic        loc_req,
  input logic        loc_we,
  input logic        ext_req,
  input logic        wr_q,
  input logic [2:0]  sz_q
);
  logic take, nf, bad;
  assign take = req_valid && !req_busy;
  assign nf   = (req_dev != 5'd0) && ((req_bus == root_bus) || (req_primary == root_bus));
  assign bad  = !((req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4)) ||
                ((req_size == 3'd2) && req_reg[0]) ||
                ((req_size == 3'd4) && (req_reg[1:0] != 2'b00));

  assert_filter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && nf) |=> (rsp_valid && rsp_status == 2'd1));
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_req && ext_req));
  assert_bad_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nf && bad) |=> (rsp_valid && rsp_status == 2'd2));
  assert_no_read_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && wr_q && sz_q == 3'd4) |-> loc_we);
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !wr_q && sz_q == 3'd1) |-> (rsp_data[31:8] == 24'd0));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_busy);
endmodule

bind cfg_router cfg_router_chk chk (
  .clk(clk), .rst_n(rst_n), .root_bus(root_bus), .req_valid(req_valid),
  .req_busy(req_busy), .req_bus(req_bus), .req_primary(req_primary),
  .req_dev(req_dev), .req_reg(req_reg), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
  .loc_req(loc_req), .loc_we(loc_we), .ext_req(ext_req),
  .wr_q(wr_q), .sz_q(sz_q)
);

// File: tb/cfg_router_test.sv
module cfg_router_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  root_bus = 8'd0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_primary = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_reg = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_busy, rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_data;
  logic        loc_req, loc_we, ext_req, ext_we;
  logic [9:0]  loc_addr;
  logic [31:0] loc_wdata, ext_wdata;
  logic [31:0] loc_rdata, ext_rdata;
  logic        loc_ack, ext_ack;
  logic [27:0] ext_addr;
  logic [2:0]  ext_size;

  int checks = 0, errors = 0;
  int loc_rd_n = 0, loc_wr_n = 0, ext_n = 0;
  logic [27:0] ext_last_addr;
  logic [2:0]  ext_last_size;
  logic [31:0] ext_last_wdata;
  logic        ext_last_we;
  logic [31:0] lmem [0:1023];
  logic [1:0]  got_st;
  logic [31:0] got_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_router uut (.*);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_ack <= 1'b0; loc_rdata <= '0; ext_ack <= 1'b0; ext_rdata <= '0;
    end else begin
      loc_ack <= loc_req && !loc_ack;
      if (loc_req && !loc_ack) begin
        loc_rdata <= lmem[loc_addr];
        if (loc_we) begin lmem[loc_addr] <= loc_wdata; loc_wr_n <= loc_wr_n + 1; end
        else loc_rd_n <= loc_rd_n + 1;
      end
      ext_ack <= ext_req && !ext_ack;
      if (ext_req && !ext_ack) begin
        ext_rdata      <= 32'hC3A5_0000 ^ {4'h0, ext_addr};
        ext_last_addr  <= ext_addr;
        ext_last_size  <= ext_size;
        ext_last_wdata <= ext_wdata;
        ext_last_we    <= ext_we;
        ext_n          <= ext_n + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [7:0] b, input logic [7:0] p,
                      input logic [4:0] d, input logic [2:0] f, input logic [11:0] r,
                      input logic [2:0] s, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bus = b; req_primary = p;
    req_dev = d; req_fn = f; req_reg = r; req_size = s; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
    got_st = rsp_status;
    got_d  = rsp_data;
  endtask

  task automatic t_reset;
    chk("R10 busy", {31'd0, req_busy}, 0);
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R10 target reqs", {30'd0, loc_req, ext_req}, 0);
  endtask

  task automatic t_local_full;
    int r0 = loc_rd_n, w0 = loc_wr_n, e0 = ext_n;
    xfer(1, 8'd0, 8'd0, 0, 0, 12'h010, 4, 32'h1122_3344);
    chk("R9 status", got_st, 0);
    chk("R6 reads", loc_rd_n - r0, 0);
    chk("R6 writes", loc_wr_n - w0, 1);
    chk("R2 no ext", ext_n - e0, 0);
    xfer(0, 8'd0, 8'd0, 0, 0, 12'h010, 4, 0);
    chk("R7 full read", got_d, 32'h1122_3344);
  endtask

  task automatic t_local_narrow;
    int r0 = loc_rd_n, w0 = loc_wr_n;
    xfer(1, 8'd0, 8'd0, 0, 0, 12'h011, 1, 32'hFFFF_FFAB);
    chk("R5 byte rmw reads", loc_rd_n - r0, 1);
    chk("R5 byte rmw writes", loc_wr_n - w0, 1);
    chk("R5 byte merge", lmem[4], 32'h1122_AB44);
    xfer(1, 8'd0, 8'd0, 0, 0, 12'h012, 2, 32'h0000_BEEF);
    chk("R5 half merge", lmem[4], 32'hBEEF_AB44);
    xfer(0, 8'd0, 8'd0, 0, 0, 12'h013, 1, 0);
    chk("R7 byte lane 3", got_d, 32'h0000_00BE);
    xfer(0, 8'd0, 8'd0, 0, 0, 12'h010, 2, 0);
    chk("R7 half lane 0", got_d, 32'h0000_AB44);
  endtask

  task automatic t_ext;
    int l0 = loc_rd_n + loc_wr_n;
    logic [27:0] a;
    a = {8'd2, 5'd3, 3'd5, 12'h104};
    xfer(0, 8'd2, 8'd1, 3, 5, 12'h104, 4, 0);
    chk("R3 ecam addr", {4'h0, ext_last_addr}, {4'h0, a});
    chk("R3 read data", got_d, 32'hC3A5_0000 ^ {4'h0, a});
    chk("R2 no local", (loc_rd_n + loc_wr_n) - l0, 0);
    xfer(1, 8'd7, 8'd4, 0, 1, 12'h00E, 2, 32'h1234_5678);
    chk("R3 write size", {29'd0, ext_last_size}, 2);
    chk("R3 write data", ext_last_wdata, 32'h0000_5678);
    chk("R3 write flag", {31'd0, ext_last_we}, 1);
    a = {8'd9, 5'd0, 3'd0, 12'h0A1};
    xfer(0, 8'd9, 8'd6, 0, 0, 12'h0A1, 1, 0);
    chk("R7 ext byte", got_d, (32'hC3A5_0000 ^ {4'h0, a}) & 32'hFF);
  endtask

  task automatic t_filter;
    int n0 = loc_rd_n + loc_wr_n + ext_n;
    xfer(0, 8'd0, 8'd0, 1, 0, 12'h000, 4, 0);
    chk("R1 root dev1", got_st, 1);
    xfer(1, 8'd1, 8'd0, 2, 0, 12'h000, 4, 0);
    chk("R1 secondary dev2", got_st, 1);
    xfer(0, 8'd0, 8'd0, 4, 0, 12'h001, 4, 0);
    chk("R1 priority over R4", got_st, 1);
    chk("R1 no access", (loc_rd_n + loc_wr_n + ext_n) - n0, 0);
    xfer(0, 8'd1, 8'd0, 0, 0, 12'h000, 4, 0);
    chk("R1 secondary dev0 ok", got_st, 0);
  endtask

  task automatic t_align;
    int n0 = loc_rd_n + loc_wr_n + ext_n;
    xfer(0, 8'd0, 8'd0, 0, 0, 12'h001, 2, 0);
    chk("R4 half odd", got_st, 2);
    xfer(1, 8'd3, 8'd2, 0, 0, 12'h002, 4, 0);
    chk("R4 word offset 2", got_st, 2);
    xfer(0, 8'd3, 8'd2, 0, 0, 12'h000, 3, 0);
    chk("R4 size 3", got_st, 2);
    xfer(0, 8'd0, 8'd0, 0, 0, 12'h000, 0, 0);
    chk("R4 size 0", got_st, 2);
    chk("R4 no access", (loc_rd_n + loc_wr_n + ext_n) - n0, 0);
  endtask

  task automatic t_busy;
    int pulses = 0;
    lmem[8] = 32'hCAFE_F00D;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_bus = 0; req_primary = 0; req_dev = 0;
    req_fn = 0; req_reg = 12'h000; req_size = 4;
    @(negedge clk);
    chk("R8 busy after accept", {31'd0, req_busy}, 1);
    req_write = 1; req_reg = 12'h020; req_wdata = 32'h0;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 12; i++) begin
      if (rsp_valid) pulses++;
      @(negedge clk);
    end
    chk("R8 single response", pulses, 1);
    chk("R8 ignored write", lmem[8], 32'hCAFE_F00D);
    chk("R8 idle after", {31'd0, req_busy}, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) lmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_local_full();
    t_local_narrow();
    t_ext();
    t_filter();
    t_align();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule